// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Alternating Steering

This block is the digital timing core of a push-pull switching converter. A period counter runs freely, or restarts on an external sync edge, and acts as the ramp. Each period opens with a blanking interval in which both drive legs are held off. After blanking, a single pulse lasts until the ramp reaches the duty command. That pulse goes to one of two legs, and a steering flip-flop swaps the legs between pulses so that the transformer core sees alternating polarity.

Shutdown and overcurrent both cut the pulse at once, and a per-period latch stops it from coming back before the next period. The steering flip-flop advances only after a period that actually delivered a pulse. Because of this, no leg is driven twice in a row, even when periods with no pulse (shutdown, zero duty, an early sync) fall in between. The block drives a period-start strobe that a master instance can use to restart slave instances on a shared sync line. The period, duty and blanking words are captured only when a period starts.

Top module: `pushpull_pwm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_a, out_b and sync_out are low. The first period after reset lasts the commanded length, issues no pulse and raises no sync_out. The first pulse after that goes to out_a.
- R2: With no sync input, each period lasts max(period_word, 2) cycles. sync_out is high only in the first cycle of each period, from the second period after reset onward.
- R3: Counting the cycle where sync_out is high as index 0, both outputs are low for indices below max(blank_word, 1). out_a and out_b are never high together.
- R4: With no override, the selected leg is high exactly for indices i with max(blank_word,1) <= i < min(duty_word, L), where L is the period length. This gives one contiguous pulse of max(0, min(duty_word, L) - max(blank_word,1)) cycles, and a duty at or below the blanking length gives no pulse.
- R5: Successive pulses alternate between out_a and out_b. The steering advances at a period start only if the period that just ended produced a pulse, so a leg is never pulsed twice in succession across shutdown or pulse-free periods.
- R6: If shutdown or overcurrent is high in a cycle, both outputs are low in the next cycle. If an override is seen at or after the end of blanking, no further pulse appears in that period even once it is released. An override that ends before blanking ends has no effect. The following period is unaffected.
- R7: period_word, duty_word and blank_word are captured at each period start. A change made during a period takes effect only at the next period start.
- R8: A rising edge of sync_in that is high at the clock edge ending index k restarts the period so that index 0 of the new period is index k+3 of the old one. A level held high gives one restart only.
- R9: A sync restart that lands before any pulse of the current period does not advance the steering. The next pulse goes to the leg that was due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_word | input | PWM_W | Ramp count at which the pulse ends |
| period_word | input | PWM_W | Free-running period length in cycles (minimum 2) |
| blank_word | input | PWM_W | Blanking length at each period start (minimum 1) |
| sync_in | input | 1 | Asynchronous external restart, rising-edge sensitive |
| shutdown | input | 1 | Forces both legs off |
| overcurrent | input | 1 | Current-limit override, forces both legs off |
| out_a | output | 1 | Drive for leg A |
| out_b | output | 1 | Drive for leg B |
| sync_out | output | 1 | One-cycle strobe at each period start |

## Verification
The bench sweeps every small combination of period, blanking and duty words, including the clamped values 0 and 1 and duty values past the period end. A design that clamped wrongly or compared off by one would show a pulse one cycle too long or starting inside blanking. Overrides are placed before, across and inside the pulse window. A missing per-period latch would produce a second pulse once the override is released, and a late override path would leave the pulse running one cycle longer. Shutdown is held over an odd number of periods, and a sync restart is placed inside blanking. A design that toggles its steering on every period start would then pulse the same leg twice, which the bench detects.

// File: rtl/pushpull_pwm_pkg.sv
`timescale 1ns/1ps
package pushpull_pwm_pkg;

    localparam int unsigned PWM_W      = 8;
    localparam int unsigned MIN_PERIOD = 2;
    localparam int unsigned MIN_BLANK  = 1;

    typedef logic [PWM_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t period;
        cnt_t duty;
        cnt_t blank;
    } frame_cfg_t;

    typedef enum logic {
        LEG_A = 1'b0,
        LEG_B = 1'b1
    } leg_t;

    function automatic cnt_t floor_at(cnt_t v, int unsigned lo);
        return (v < cnt_t'(lo)) ? cnt_t'(lo) : v;
    endfunction

    // Legalise a raw command set before it governs a period.
    function automatic frame_cfg_t sanitize(frame_cfg_t raw);
        frame_cfg_t c;
        c.period = floor_at(raw.period, MIN_PERIOD);
        c.blank  = floor_at(raw.blank, MIN_BLANK);
        c.duty   = raw.duty;
        return c;
    endfunction

    function automatic leg_t other_leg(leg_t l);
        return (l == LEG_A) ? LEG_B : LEG_A;
    endfunction

endpackage

// File: rtl/pushpull_pwm_sync.sv
`timescale 1ns/1ps
module pushpull_pwm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[STAGES-1:0] resynchronise, chain[STAGES] holds the previous level
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/pushpull_pwm_ramp.sv
`timescale 1ns/1ps
module pushpull_pwm_ramp
    import pushpull_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cmd,
    input  logic       sync_evt,
    output cnt_t       ramp,
    output frame_cfg_t cfg,
    output logic       restart,
    output logic       armed,
    output logic       frame_start
);
    cnt_t       ramp_q;
    frame_cfg_t cfg_q;
    logic       armed_q;
    logic       wrap;

    assign wrap    = (ramp_q >= (cfg_q.period - cnt_t'(1)));
    assign restart = wrap | sync_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q  <= '0;
            cfg_q   <= sanitize(cmd);
            armed_q <= 1'b0;
        end else if (restart) begin
            ramp_q  <= '0;
            cfg_q   <= sanitize(cmd);
            armed_q <= 1'b1;
        end else begin
            ramp_q  <= ramp_q + cnt_t'(1);
        end
    end

    assign ramp        = ramp_q;
    assign cfg         = cfg_q;
    assign armed       = armed_q;
    assign frame_start = armed_q & (ramp_q == '0);

endmodule

// File: rtl/pushpull_pwm_pulse.sv
`timescale 1ns/1ps
module pushpull_pwm_pulse
    import pushpull_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cnt_t       ramp,
    input  frame_cfg_t cfg,
    input  logic       restart,
    input  logic       armed,
    input  logic       kill_req,
    output logic       drv_a,
    output logic       drv_b
);
    logic kill_q;
    logic done_q;
    logic fired_q;
    leg_t leg_q;
    logic past_blank;
    logic in_window;
    logic active;

    assign past_blank = (ramp >= cfg.blank);
    assign in_window  = past_blank & (ramp < cfg.duty);
    assign active     = armed & ~done_q & ~kill_q & in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_q  <= 1'b0;
            done_q  <= 1'b0;
            fired_q <= 1'b0;
            leg_q   <= LEG_A;
        end else begin
            kill_q <= kill_req;
            if (restart) begin
                done_q  <= 1'b0;
                fired_q <= 1'b0;
                if (fired_q | active) begin
                    leg_q <= other_leg(leg_q);
                end
            end else begin
                // once past blanking, any idle cycle closes the period's pulse
                done_q  <= done_q | (past_blank & ~active);
                fired_q <= fired_q | active;
            end
        end
    end

    assign drv_a = active & (leg_q == LEG_A);
    assign drv_b = active & (leg_q == LEG_B);

endmodule

// File: rtl/pushpull_pwm.sv
`timescale 1ns/1ps
module pushpull_pwm
    import pushpull_pwm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWM_W-1:0] duty_word,
    input  logic [PWM_W-1:0] period_word,
    input  logic [PWM_W-1:0] blank_word,
    input  logic             sync_in,
    input  logic             shutdown,
    input  logic             overcurrent,
    output logic             out_a,
    output logic             out_b,
    output logic             sync_out
);
    frame_cfg_t cmd;
    frame_cfg_t cfg;
    cnt_t       ramp;
    logic       restart;
    logic       armed;
    logic       sync_rise;
    logic       frame_start;

    assign cmd.period = period_word;
    assign cmd.duty   = duty_word;
    assign cmd.blank  = blank_word;

    pushpull_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (sync_rise)
    );

    pushpull_pwm_ramp u_ramp (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .sync_evt    (sync_rise),
        .ramp        (ramp),
        .cfg         (cfg),
        .restart     (restart),
        .armed       (armed),
        .frame_start (frame_start)
    );

    pushpull_pwm_pulse u_pulse (
        .clk      (clk),
        .rst      (rst),
        .ramp     (ramp),
        .cfg      (cfg),
        .restart  (restart),
        .armed    (armed),
        .kill_req (shutdown | overcurrent),
        .drv_a    (out_a),
        .drv_b    (out_b)
    );

    assign sync_out = frame_start;

endmodule

// File: rtl/pushpull_pwm_chk.sv
`timescale 1ns/1ps
module pushpull_pwm_chk (
    input logic clk,
    input logic rst,
    input logic out_a,
    input logic out_b,
    input logic sync_out,
    input logic shutdown,
    input logic overcurrent
);
    logic       prev_a;
    logic       prev_b;
    logic [1:0] last_leg;   // 0 none yet, 1 leg A, 2 leg B
    logic [1:0] rises_q;
    logic       rise_a;
    logic       rise_b;

    assign rise_a = out_a & ~prev_a;
    assign rise_b = out_b & ~prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a   <= 1'b0;
            prev_b   <= 1'b0;
            last_leg <= 2'd0;
            rises_q  <= 2'd0;
        end else begin
            prev_a <= out_a;
            prev_b <= out_b;
            if (rise_a) last_leg <= 2'd1;
            else if (rise_b) last_leg <= 2'd2;
            if (sync_out) rises_q <= 2'd0;
            else if ((rise_a | rise_b) && rises_q != 2'd3) rises_q <= rises_q + 2'd1;
        end
    end

    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b)); // R3

    AST_BLANK_AT_START: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (!out_a && !out_b)); // R3

    AST_SYNC_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_out |=> !sync_out); // R2

    AST_OVERRIDE_CUTS: assert property (@(posedge clk) disable iff (rst)
        (shutdown || overcurrent) |=> (!out_a && !out_b)); // R6

    AST_ONE_PULSE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rise_a || rise_b) |-> (rises_q == 2'd0)); // R4

    AST_ALTERNATE_A: assert property (@(posedge clk) disable iff (rst)
        rise_a |-> (last_leg != 2'd1)); // R5

    AST_ALTERNATE_B: assert property (@(posedge clk) disable iff (rst)
        rise_b |-> (last_leg == 2'd1)); // R5

endmodule

bind pushpull_pwm pushpull_pwm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_a       (out_a),
    .out_b       (out_b),
    .sync_out    (sync_out),
    .shutdown    (shutdown),
    .overcurrent (overcurrent)
);

// File: tb/tb_pushpull_pwm.sv
`timescale 1ns/1ps
module tb_pushpull_pwm;
    import pushpull_pwm_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PWM_W-1:0] duty_word = '0;
    logic [PWM_W-1:0] period_word = '0;
    logic [PWM_W-1:0] blank_word = '0;
    logic             sync_in = 1'b0;
    logic             shutdown = 1'b0;
    logic             overcurrent = 1'b0;
    logic             out_a;
    logic             out_b;
    logic             sync_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int  cur_p, cur_b, cur_d;
    bit  nxt_b = 1'b0;
    bit  first_pulse_seen = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pushpull_pwm dut (
        .clk         (clk),
        .rst         (rst),
        .duty_word   (duty_word),
        .period_word (period_word),
        .blank_word  (blank_word),
        .sync_in     (sync_in),
        .shutdown    (shutdown),
        .overcurrent (overcurrent),
        .out_a       (out_a),
        .out_b       (out_b),
        .sync_out    (sync_out)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_kill(input bit use_sd, input bit v);
        if (use_sd) shutdown = v;
        else overcurrent = v;
    endtask

    // Called at the negedge of index 0 of a period (sync_out just seen high).
    // Drives the next command set, runs the period and checks it against the
    // command set in effect. Returns at index 0 of the following period.
    task automatic step(input int np, input int nb, input int nd,
                        input int kill_idx, input int kill_len, input bit use_sd,
                        input int sync_idx, input string tag);
        int pe, be, lx, endw, on_exp, ks, ke;
        int len, ca, cb, first, both, rises;
        bit prev_on;
        pe = (cur_p < 2) ? 2 : cur_p;
        be = (cur_b < 1) ? 1 : cur_b;
        lx = (sync_idx >= 0 && sync_idx + 3 <= pe) ? sync_idx + 3 : pe;
        endw = (cur_d < lx) ? cur_d : lx;
        on_exp = (endw > be) ? endw - be : 0;
        if (kill_idx >= 0 && on_exp > 0) begin
            ks = kill_idx + 1;
            ke = kill_idx + kill_len;
            if (!(ke < be || ks >= endw)) on_exp = ((ks > be) ? ks : be) - be;
        end
        period_word = cnt_t'(np);
        blank_word  = cnt_t'(nb);
        duty_word   = cnt_t'(nd);
        shutdown    = use_sd && (kill_idx == 0);
        overcurrent = !use_sd && (kill_idx == 0);
        sync_in     = (sync_idx == 0);
        len = 0; ca = 0; cb = 0; first = -1; both = 0; rises = 0; prev_on = 1'b0;
        do begin
            if (out_a || out_b) begin
                if (first < 0) first = len;
                if (!prev_on) rises++;
            end
            prev_on = out_a || out_b;
            ca += int'(out_a);
            cb += int'(out_b);
            if (out_a && out_b) both++;
            @(negedge clk);
            len++;
            if (kill_idx >= 0 && len == kill_idx) drive_kill(use_sd, 1'b1);
            if (kill_idx >= 0 && len == kill_idx + kill_len) drive_kill(use_sd, 1'b0);
            if (sync_idx >= 0 && len == sync_idx) sync_in = 1'b1;
        end while (!sync_out && len < 1000);

        check(len == lx, (sync_idx >= 0) ? "R8" : "R2", "period length", len, lx);
        check(ca + cb == on_exp, tag, "pulse cycles", ca + cb, on_exp);
        check(both == 0, "R3", "cycles with both legs high", both, 0);
        check(rises <= 1, "R4", "pulses in one period", rises, 1);
        if (on_exp > 0) begin
            check(first == be, "R3", "pulse start index", first, be);
            if (!first_pulse_seen) begin
                check(ca == on_exp, "R1", "first pulse on leg A", ca, on_exp);
                first_pulse_seen = 1'b1;
            end
            check((nxt_b ? cb : ca) == on_exp, "R5", nxt_b ? "cycles on leg B" : "cycles on leg A",
                  nxt_b ? cb : ca, on_exp);
            nxt_b = !nxt_b;
        end
        cur_p = np; cur_b = nb; cur_d = nd;
    endtask

    initial begin
        int len, pulses;
        period_word = cnt_t'(6);
        blank_word  = cnt_t'(2);
        duty_word   = cnt_t'(5);
        cur_p = 6; cur_b = 2; cur_d = 5;
        repeat (3) @(negedge clk);
        check(!out_a && !out_b && !sync_out, "R1", "outputs during reset",
              int'(out_a) + int'(out_b) + int'(sync_out), 0);
        rst = 1'b0;
        check(!out_a && !out_b && !sync_out, "R1", "outputs after reset",
              int'(out_a) + int'(out_b) + int'(sync_out), 0);
        len = 0; pulses = 0;
        while (!sync_out && len < 1000) begin
            pulses += int'(out_a) + int'(out_b);
            @(negedge clk);
            len++;
        end
        check(len == 6, "R1", "first period length", len, 6);
        check(pulses == 0, "R1", "pulse cycles in first period", pulses, 0);

        step(6, 2, 5, -1, 0, 1'b0, -1, "R4");
        // Near-exhaustive sweep; each new command set takes effect one period later (R7).
        for (int p = 0; p <= 8; p++)
            for (int b = 0; b <= p + 1; b++)
                for (int d = 0; d <= p + 2; d++)
                    step(p, b, d, -1, 0, 1'b0, -1, "R4");
        step(10, 2, 8, -1, 0, 1'b0, -1, "R4");

        // Overrides, window indices 2..7
        step(10, 2, 8, 4, 1, 1'b0, -1, "R6");
        step(10, 2, 8, -1, 0, 1'b0, -1, "R6");
        step(10, 2, 8, 0, 1, 1'b0, -1, "R6");
        step(10, 2, 8, 1, 2, 1'b0, -1, "R6");
        step(10, 2, 8, 5, 1, 1'b1, -1, "R6");
        // Shutdown held for three periods, then released
        step(10, 2, 8, 0, 100000, 1'b1, -1, "R5");
        step(10, 2, 8, 0, 100000, 1'b1, -1, "R5");
        step(10, 2, 8, 0, 100000, 1'b1, -1, "R5");
        step(10, 2, 8, -1, 0, 1'b0, -1, "R5");

        // Mid-period command change has no effect on the running period
        step(10, 2, 3, -1, 0, 1'b0, -1, "R7");
        step(10, 2, 8, -1, 0, 1'b0, -1, "R7");
        step(12, 2, 8, -1, 0, 1'b0, -1, "R7");

        // External sync
        step(12, 2, 8, -1, 0, 1'b0, 6, "R8");
        step(12, 6, 10, -1, 0, 1'b0, -1, "R8");
        step(12, 6, 10, -1, 0, 1'b0, 1, "R9");
        step(12, 6, 10, -1, 0, 1'b0, -1, "R9");
        step(12, 6, 10, -1, 0, 1'b0, -1, "R9");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400us;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule